// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block turns activity on a 32-bit general-purpose input port into per-pin interrupt requests. Each pin can first pass through an optional stability filter. The filter's result then feeds four independently enabled event detectors: rising edge, falling edge, level high and level low. Any enabled event latches a sticky status bit. Software clears status bits by writing ones to them. Software can also inject events through a write-only trigger register. A per-pin interrupt enable decides which status bits drive the interrupt outputs.

Software reaches the block through a simple synchronous register port made of write enable, read enable, word address, byte enables and 32-bit data. Read data and the error flag are combinational in the same cycle as the request. Writes take effect at the next clock edge.

Each pin filter is a two-state machine. In `FLT_STEADY`, the filter holds the accepted value. The transition *start-settle* to `FLT_SETTLE` happens when the raw input differs from the accepted value. In `FLT_SETTLE`, a counter runs while the input keeps its new value. The transition *accept* returns to `FLT_STEADY` and adopts the new value once the count completes. The transition *abandon* returns to `FLT_STEADY` without changing the accepted value if the input falls back to it. Clearing the pin's filter enable forces `FLT_STEADY`, and the accepted value then tracks the raw input.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is zero.
- R2: With a pin's rising-edge enable set, a 0-to-1 change of its filtered value between consecutive clock edges sets its status bit at the second of those edges.
- R3: With a pin's falling-edge enable set, a 1-to-0 change of its filtered value sets its status bit in the same way.
- R4: With a pin's level-high enable set, its status bit is set at every edge where its filtered value is 1.
- R5: With a pin's level-low enable set, its status bit is set at every edge where its filtered value is 0.
- R6: Writing the status register (address 0) clears each bit written as 1 and leaves bits written as 0 unchanged. If a hardware set hits the same bit in the same cycle, the set wins. Status bits never fall without such a write.
- R7: A write to the trigger register (address 2) sets the written bits in status at that edge and stores nothing. Reading address 2 returns zero.
- R8: `irq_o` equals status ANDed with the interrupt enable register (address 1).
- R9: For a pin with its bit set in the filter enable register (address 8), a new value is accepted only after it has been present at 16 consecutive edges, and a shorter excursion is discarded. With the bit clear, the pin passes straight through. The pin register (address 3, read-only) returns the filtered values.
- R10: A read of an address above 8 returns all ones and raises `reg_err`. A write to such an address raises `reg_err` and changes nothing.
- R11: A write whose byte enables are not all 1 raises `reg_err` and changes no register.
- R12: Word addresses: 0 status, 1 interrupt enable, 2 trigger, 3 pins, 4 rising enable, 5 falling enable, 6 level-high enable, 7 level-low enable, 8 filter enable. Bit n of every register belongs to pin n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 32 | Synchronized pin inputs |
| reg_we | input | 1 | Register write request |
| reg_re | input | 1 | Register read request |
| reg_addr | input | 4 | Word address |
| reg_be | input | 4 | Byte enables of a write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, same cycle |
| reg_err | output | 1 | Access error, same cycle |
| irq_o | output | 32 | Per-pin interrupt requests |

## Verification
The hardest case to reach from the ports is a hardware event and a software clear landing on the same status bit at the same edge. Reaching it takes a level enable, a matching pin value and a clear write all aligned in one cycle. Directed steps hold a pin high under a level-high enable while writing its clear. A random phase then mixes sparse enables, random pin patterns and random clear masks, so that such coincidences occur many times. The filter boundary is reached by holding a changed input for exactly 15 and then 16 edges, and by an excursion that returns before the count completes.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int REG_AW = 4;

    localparam logic [REG_AW-1:0] ADR_STAT = 4'd0;
    localparam logic [REG_AW-1:0] ADR_IEN  = 4'd1;
    localparam logic [REG_AW-1:0] ADR_TRIG = 4'd2;
    localparam logic [REG_AW-1:0] ADR_PINS = 4'd3;
    localparam logic [REG_AW-1:0] ADR_RISE = 4'd4;
    localparam logic [REG_AW-1:0] ADR_FALL = 4'd5;
    localparam logic [REG_AW-1:0] ADR_HIGH = 4'd6;
    localparam logic [REG_AW-1:0] ADR_LOW  = 4'd7;
    localparam logic [REG_AW-1:0] ADR_FILT = 4'd8;

    typedef enum logic {
        FLT_STEADY,
        FLT_SETTLE
    } flt_state_e;
endpackage

// File: rtl/gpio_pin_filter.sv
module gpio_pin_filter
    import gpio_irq_pkg::*;
#(
    parameter int HOLD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic raw,
    output logic filt
);
    localparam int CW = $clog2(HOLD + 1);

    flt_state_e    state_q, state_d;
    logic          held_q, held_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_STEADY;
            held_q  <= 1'b0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            held_q  <= held_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and data path
    always_comb begin
        state_d = state_q;
        held_d  = held_q;
        cnt_d   = cnt_q;
        if (!en) begin
            state_d = FLT_STEADY;
            held_d  = raw;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                FLT_STEADY: begin
                    if (raw != held_q) begin
                        state_d = FLT_SETTLE;
                        cnt_d   = CW'(1);
                    end
                end
                FLT_SETTLE: begin
                    if (raw == held_q) begin
                        state_d = FLT_STEADY;
                        cnt_d   = '0;
                    end else if (cnt_q == CW'(HOLD - 1)) begin
                        state_d = FLT_STEADY;
                        held_d  = raw;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
            endcase
        end
    end

    // output
    always_comb begin
        filt = en ? held_q : raw;
    end
endmodule

// File: rtl/gpio_event_detect.sv
module gpio_event_detect #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] filt,
    input  logic [NPINS-1:0] en_rise,
    input  logic [NPINS-1:0] en_fall,
    input  logic [NPINS-1:0] en_high,
    input  logic [NPINS-1:0] en_low,
    output logic [NPINS-1:0] ev
);
    logic [NPINS-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= filt;
    end

    always_comb begin
        ev = (en_rise & filt & ~prev_q)
           | (en_fall & ~filt & prev_q)
           | (en_high & filt)
           | (en_low & ~filt);
    end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [NPINS/8-1:0] reg_be,
    input  logic [NPINS-1:0]  reg_wdata,
    output logic [NPINS-1:0]  reg_rdata,
    output logic              reg_err,
    input  logic [NPINS-1:0]  ev,
    input  logic [NPINS-1:0]  pins_view,
    output logic [NPINS-1:0]  stat,
    output logic [NPINS-1:0]  ien,
    output logic [NPINS-1:0]  en_rise,
    output logic [NPINS-1:0]  en_fall,
    output logic [NPINS-1:0]  en_high,
    output logic [NPINS-1:0]  en_low,
    output logic [NPINS-1:0]  filt_en
);
    logic             hit, wr_ok;
    logic [NPINS-1:0] clr, trig;

    always_comb begin
        hit   = (reg_addr <= ADR_FILT);
        wr_ok = reg_we && hit && (&reg_be);
        clr   = (wr_ok && reg_addr == ADR_STAT) ? reg_wdata : '0;
        trig  = (wr_ok && reg_addr == ADR_TRIG) ? reg_wdata : '0;
        reg_err = (reg_re && !hit) || (reg_we && !(hit && (&reg_be)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat    <= '0;
            ien     <= '0;
            en_rise <= '0;
            en_fall <= '0;
            en_high <= '0;
            en_low  <= '0;
            filt_en <= '0;
        end else begin
            stat <= (stat & ~clr) | ev | trig;
            if (wr_ok) begin
                unique case (reg_addr)
                    ADR_IEN:  ien     <= reg_wdata;
                    ADR_RISE: en_rise <= reg_wdata;
                    ADR_FALL: en_fall <= reg_wdata;
                    ADR_HIGH: en_high <= reg_wdata;
                    ADR_LOW:  en_low  <= reg_wdata;
                    ADR_FILT: filt_en <= reg_wdata;
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            ADR_STAT: reg_rdata = stat;
            ADR_IEN:  reg_rdata = ien;
            ADR_TRIG: reg_rdata = '0;
            ADR_PINS: reg_rdata = pins_view;
            ADR_RISE: reg_rdata = en_rise;
            ADR_FALL: reg_rdata = en_fall;
            ADR_HIGH: reg_rdata = en_high;
            ADR_LOW:  reg_rdata = en_low;
            ADR_FILT: reg_rdata = filt_en;
            default:  reg_rdata = '1;
        endcase
    end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int HOLD  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NPINS-1:0]   pins_i,
    input  logic               reg_we,
    input  logic               reg_re,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [NPINS/8-1:0] reg_be,
    input  logic [NPINS-1:0]   reg_wdata,
    output logic [NPINS-1:0]   reg_rdata,
    output logic               reg_err,
    output logic [NPINS-1:0]   irq_o
);
    logic [NPINS-1:0] filt, ev, stat, ien;
    logic [NPINS-1:0] en_rise, en_fall, en_high, en_low, filt_en;

    for (genvar g = 0; g < NPINS; g++) begin : g_flt
        gpio_pin_filter #(.HOLD(HOLD)) u_flt (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (filt_en[g]),
            .raw  (pins_i[g]),
            .filt (filt[g])
        );
    end

    gpio_event_detect #(.NPINS(NPINS)) u_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .filt   (filt),
        .en_rise(en_rise),
        .en_fall(en_fall),
        .en_high(en_high),
        .en_low (en_low),
        .ev     (ev)
    );

    gpio_irq_regs #(.NPINS(NPINS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_re   (reg_re),
        .reg_addr (reg_addr),
        .reg_be   (reg_be),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .reg_err  (reg_err),
        .ev       (ev),
        .pins_view(filt),
        .stat     (stat),
        .ien      (ien),
        .en_rise  (en_rise),
        .en_fall  (en_fall),
        .en_high  (en_high),
        .en_low   (en_low),
        .filt_en  (filt_en)
    );

    always_comb begin
        irq_o = stat & ien;
    end
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_we,
    input logic               reg_re,
    input logic [REG_AW-1:0]  reg_addr,
    input logic [NPINS/8-1:0] reg_be,
    input logic [NPINS-1:0]   reg_wdata,
    input logic [NPINS-1:0]   reg_rdata,
    input logic               reg_err,
    input logic [NPINS-1:0]   stat
);
    // R10
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_re && reg_addr > ADR_FILT) |-> (reg_err && reg_rdata == '1));

    // R11
    partial_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !(&reg_be)) |-> reg_err);

    // R7
    trig_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_re && reg_addr == ADR_TRIG) |-> (reg_rdata == '0));

    // R7
    trig_sets_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && (&reg_be) && reg_addr == ADR_TRIG)
        |=> ((stat & $past(reg_wdata)) == $past(reg_wdata)));

    // R6
    stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == ADR_STAT) |=> ((stat & $past(stat)) == $past(stat)));
endmodule

bind gpio_irq_unit gpio_irq_chk #(.NPINS(NPINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_re   (reg_re),
    .reg_addr (reg_addr),
    .reg_be   (reg_be),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .reg_err  (reg_err),
    .stat     (stat)
);

// File: tb/tb_gpio_irq_unit.sv
module tb_gpio_irq_unit;
    import gpio_irq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 32;

    logic          clk, rst_n;
    logic [NP-1:0] pins_i;
    logic          reg_we, reg_re;
    logic [3:0]    reg_addr;
    logic [3:0]    reg_be;
    logic [NP-1:0] reg_wdata;
    logic [NP-1:0] reg_rdata;
    logic          reg_err;
    logic [NP-1:0] irq_o;

    gpio_irq_unit dut (
        .clk(clk), .rst_n(rst_n), .pins_i(pins_i),
        .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
        .reg_be(reg_be), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_err(reg_err), .irq_o(irq_o)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [NP-1:0] m_stat, m_ien, m_rise, m_fall, m_high, m_low, m_prev;
    logic last_err;
    logic [NP-1:0] rv;

    function automatic logic [NP-1:0] events(input logic [NP-1:0] p, input logic [NP-1:0] pv);
        return (m_rise & p & ~pv) | (m_fall & ~p & pv) | (m_high & p) | (m_low & ~p);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: drive inputs, update model (filter off), advance past the edge
    task automatic tick(input logic [NP-1:0] p, input logic we, input logic [3:0] a,
                        input logic [NP-1:0] d, input logic [3:0] be);
        logic ok;
        logic [NP-1:0] set, clr;
        pins_i = p; reg_we = we; reg_addr = a; reg_wdata = d; reg_be = be;
        ok  = we && be == 4'hF && a <= ADR_FILT;
        set = events(p, m_prev);
        if (ok && a == ADR_TRIG) set = set | d;
        clr = (ok && a == ADR_STAT) ? d : '0;
        m_stat = (m_stat & ~clr) | set;
        m_prev = p;
        if (ok) begin
            case (a)
                ADR_IEN:  m_ien  = d;
                ADR_RISE: m_rise = d;
                ADR_FALL: m_fall = d;
                ADR_HIGH: m_high = d;
                ADR_LOW:  m_low  = d;
                default: ;
            endcase
        end
        #1;
        last_err = reg_err;
        @(posedge clk);
        #1;
        reg_we = 1'b0;
    endtask

    task automatic idle(input logic [NP-1:0] p);
        tick(p, 1'b0, 4'd0, '0, 4'hF);
    endtask

    task automatic wr(input logic [NP-1:0] p, input logic [3:0] a, input logic [NP-1:0] d);
        tick(p, 1'b1, a, d, 4'hF);
    endtask

    task automatic rd(input logic [3:0] a, output logic [NP-1:0] v);
        reg_re = 1'b1; reg_addr = a;
        #1;
        v = reg_rdata;
        last_err = reg_err;
        reg_re = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        rst_n = 0; pins_i = '0; reg_we = 0; reg_re = 0; reg_addr = '0; reg_be = '0; reg_wdata = '0;
        m_stat = '0; m_ien = '0; m_rise = '0; m_fall = '0; m_high = '0; m_low = '0; m_prev = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(posedge clk); #1;

        // R1: reset state
        for (int a = 0; a <= 8; a++) begin
            rd(4'(a), rv);
            chk(rv == '0, "R1 reset register", rv, '0);
        end
        chk(irq_o == '0, "R1 irq after reset", irq_o, '0);

        // R2: rising edge
        wr('0, ADR_RISE, 32'h8);
        idle(32'h8);
        rd(ADR_STAT, rv); chk(rv == 32'h8, "R2 rising edge", rv, 32'h8);
        idle(32'h8);
        rd(ADR_STAT, rv); chk(rv == 32'h8, "R2 held high no new edge", rv, 32'h8);
        // R6: write-one-to-clear, zeros untouched
        wr(32'h8, ADR_STAT, 32'h0);
        rd(ADR_STAT, rv); chk(rv == 32'h8, "R6 zero write keeps", rv, 32'h8);
        wr(32'h8, ADR_STAT, 32'h8);
        rd(ADR_STAT, rv); chk(rv == 32'h0, "R6 one clears", rv, 32'h0);

        // R3: falling edge
        wr(32'h8, ADR_FALL, 32'h8);
        idle(32'h0);
        rd(ADR_STAT, rv); chk(rv == 32'h8, "R3 falling edge", rv, 32'h8);
        wr(32'h0, ADR_STAT, 32'h8);
        wr(32'h0, ADR_RISE, 32'h0);
        wr(32'h0, ADR_FALL, 32'h0);

        // R4: level high, set wins over clear
        wr(32'h80, ADR_HIGH, 32'h80);
        idle(32'h80);
        rd(ADR_STAT, rv); chk(rv == 32'h80, "R4 level high", rv, 32'h80);
        wr(32'h80, ADR_STAT, 32'h80);
        rd(ADR_STAT, rv); chk(rv == 32'h80, "R6 set wins over clear", rv, 32'h80);
        wr(32'h0, ADR_HIGH, 32'h0);
        wr(32'h0, ADR_STAT, 32'hFFFF_FFFF);
        rd(ADR_STAT, rv); chk(rv == 32'h0, "R4 cleared after disable", rv, 32'h0);

        // R5: level low
        wr(32'h0, ADR_LOW, 32'h200);
        rd(ADR_STAT, rv); chk(rv == 32'h0, "R5 enable edge not yet", rv, 32'h0);
        idle(32'h0);
        rd(ADR_STAT, rv); chk(rv == 32'h200, "R5 level low", rv, 32'h200);
        wr(32'h0, ADR_LOW, 32'h0);
        wr(32'h0, ADR_STAT, 32'h200);

        // R7: trigger register
        wr(32'h0, ADR_TRIG, 32'hA000_0000);
        rd(ADR_STAT, rv); chk(rv == 32'hA000_0000, "R7 trigger sets", rv, 32'hA000_0000);
        rd(ADR_TRIG, rv); chk(rv == 32'h0, "R7 trigger reads zero", rv, 32'h0);

        // R8: interrupt enable
        wr(32'h0, ADR_IEN, 32'h8000_0001);
        chk(irq_o == 32'h8000_0000, "R8 masked irq", irq_o, 32'h8000_0000);

        // R10: unmapped access
        rd(4'd12, rv);
        chk(rv == 32'hFFFF_FFFF && last_err, "R10 unmapped read", rv, 32'hFFFF_FFFF);
        tick(32'h0, 1'b1, 4'd12, 32'h1234, 4'hF);
        chk(last_err == 1'b1, "R10 unmapped write error", {31'b0, last_err}, 32'h1);
        rd(ADR_IEN, rv); chk(rv == 32'h8000_0001, "R10 unmapped write no effect", rv, 32'h8000_0001);

        // R11: partial byte enables
        tick(32'h0, 1'b1, ADR_IEN, 32'h0, 4'h7);
        chk(last_err == 1'b1, "R11 partial write error", {31'b0, last_err}, 32'h1);
        rd(ADR_IEN, rv); chk(rv == 32'h8000_0001, "R11 partial write ignored", rv, 32'h8000_0001);
        wr(32'h0, ADR_STAT, 32'hFFFF_FFFF);

        // R12: register readback at mapped addresses
        wr(32'h0, ADR_RISE, 32'h1111_0000);
        wr(32'h0, ADR_HIGH, 32'h0000_0404);
        rd(ADR_RISE, rv); chk(rv == 32'h1111_0000, "R12 rising enable readback", rv, 32'h1111_0000);
        rd(ADR_HIGH, rv); chk(rv == 32'h0000_0404, "R12 level-high enable readback", rv, 32'h0000_0404);

        // random phase, filter off
        for (int i = 0; i < 600; i++) begin
            logic [NP-1:0] p, d;
            int pick;
            p = $urandom;
            d = $urandom & $urandom & $urandom;
            pick = $urandom_range(0, 19);
            if (pick < 4)       wr(p, ADR_STAT, $urandom);
            else if (pick == 4) wr(p, ADR_TRIG, d);
            else if (pick == 5) wr(p, 4'($urandom_range(4, 7)), d);
            else if (pick == 6) wr(p, ADR_IEN, $urandom);
            else                idle(p);
            rd(ADR_STAT, rv);
            chk(rv == m_stat, "R6 random status", rv, m_stat);
            chk(irq_o == (m_stat & m_ien), "R8 random irq", irq_o, m_stat & m_ien);
            rd(ADR_PINS, rv);
            chk(rv == p, "R9 pass-through pins", rv, p);
        end

        // R9: filter on pin 0, pin 1 unfiltered
        wr(32'h0, ADR_RISE, 32'h0); wr(32'h0, ADR_FALL, 32'h0);
        wr(32'h0, ADR_HIGH, 32'h0); wr(32'h0, ADR_LOW, 32'h0);
        wr(32'h0, ADR_FILT, 32'h1);
        repeat (15) idle(32'h3);
        rd(ADR_PINS, rv); chk(rv == 32'h2, "R9 not accepted after 15", rv, 32'h2);
        idle(32'h3);
        rd(ADR_PINS, rv); chk(rv == 32'h3, "R9 accepted after 16", rv, 32'h3);
        repeat (10) idle(32'h0);
        rd(ADR_PINS, rv); chk(rv == 32'h1, "R9 short dip held", rv, 32'h1);
        repeat (20) idle(32'h1);
        rd(ADR_PINS, rv); chk(rv == 32'h1, "R9 dip discarded", rv, 32'h1);
        repeat (16) idle(32'h0);
        rd(ADR_PINS, rv); chk(rv == 32'h0, "R9 low accepted", rv, 32'h0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule